// File: doc/BRIEF.md
# Parallel-Prefix State Sequence Evaluator

This block takes a fixed four-state machine, a starting state and a block of sixteen 1-bit input symbols. In a single clock cycle it produces the state the machine is in after each symbol. It does not walk the symbols one at a time. Each symbol is first turned into its transition map, a four-entry next-state lookup. The maps are then composed pairwise over a log-depth prefix network, so the combinational path grows with log2 of the block length rather than with the length itself.

The machine's transition table is a parameter. After the prefix network, every composed map is applied to the starting state, and the sixteen resulting states are registered together with the final state. A caller presents a block with `in_valid`. One cycle later `out_valid` rises and the whole state trace is available.

Top module: `fsm_prefix_eval`

## Requirements
- R1: States are 2-bit codes (A=0, B=1, C=2, D=3). The transition table `TRANS` holds the next state for symbol `b` from state `s` at bits `[(b*4+s)*2 +: 2]`. The default is: on symbol 0, A→B, B→A, C→D, D→C; on symbol 1, A→C, B→D, C→B, D→A.
- R2: Bit k of `symbols` is the (k+1)-th symbol applied. Slot k of `states` (bits `[2k+1:2k]`) equals the state reached from `init_state` after symbols 0..k have been applied in order.
- R3: `final_state` equals the state reached after all sixteen symbols.
- R4: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and the results for that block are on the outputs in that cycle.
- R5: While `in_valid` is low, `states` and `final_state` keep their values regardless of `symbols` and `init_state`.
- R6: During reset `out_valid`, `states` and `final_state` are all zero.
- R7: From state A, the symbols 0 0 1 1 1 0 1 0 1 give the states B A C B D C B A C in slots 0 to 8.
- R8: Every starting state gives correct results, including D. All-zero and all-one blocks return to the starting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture strobe for a symbol block |
| init_state | input | 2 | Starting state |
| symbols | input | 16 | Symbol block, bit 0 applied first |
| out_valid | output | 1 | Results valid |
| states | output | 32 | State after each symbol, 2 bits per slot |
| final_state | output | 2 | State after the last symbol |

## Verification
The bench targets the composition order. A network that applied the earlier map on the left would give traces that look plausible but are wrong wherever the two maps do not commute, and the reference run exposes this at once. Mis-strided levels corrupt only the upper slots, so every slot is compared against a sequential model on directed and random blocks from all four starting states. The all-one block cycles through all four states and catches any map that is dropped or applied twice. Hold checks change the inputs while `in_valid` is low; a register that was never gated would pick up the new values.

// File: rtl/fsm_prefix_eval.sv
module fsm_prefix_eval #(
  parameter int N = 16,
  parameter int SW = 2,
  parameter int NS = 1 << SW,
  parameter logic [2*NS*SW-1:0] TRANS = 16'h1EB1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [SW-1:0]   init_state,
  input  logic [N-1:0]    symbols,
  output logic            out_valid,
  output logic [N*SW-1:0] states,
  output logic [SW-1:0]   final_state
);
  localparam int MW = NS * SW;
  localparam int L  = $clog2(N);
  localparam logic [MW-1:0] MAP0 = TRANS[0 +: MW];
  localparam logic [MW-1:0] MAP1 = TRANS[MW +: MW];

  function automatic logic [MW-1:0] compose(input logic [MW-1:0] later,
                                            input logic [MW-1:0] earlier);
    logic [MW-1:0] r;
    for (int j = 0; j < NS; j++)
      r[j*SW +: SW] = later[earlier[j*SW +: SW]*SW +: SW];
    return r;
  endfunction

  logic [MW-1:0]   lvl [0:L][0:N-1];
  logic [N*SW-1:0] trace;

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign lvl[0][i] = symbols[i] ? MAP1 : MAP0;
  end

  for (genvar l = 0; l < L; l++) begin : g_lvl
    for (genvar i = 0; i < N; i++) begin : g_node
      if (i >= (1 << l)) begin : g_comb
        assign lvl[l+1][i] = compose(lvl[l][i], lvl[l][i-(1<<l)]);
      end else begin : g_pass
        assign lvl[l+1][i] = lvl[l][i];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_apply
    assign trace[i*SW +: SW] = lvl[L][i][init_state*SW +: SW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      states      <= '0;
      final_state <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        states      <= trace;
        final_state <= trace[(N-1)*SW +: SW];
      end
    end
  end
endmodule

// File: rtl/fsm_prefix_eval_chk.sv
module fsm_prefix_eval_chk #(
  parameter int N = 16,
  parameter int SW = 2,
  parameter int NS = 1 << SW,
  parameter logic [2*NS*SW-1:0] TRANS = 16'h1EB1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [SW-1:0]   init_state,
  input logic [N-1:0]    symbols,
  input logic            out_valid,
  input logic [N*SW-1:0] states,
  input logic [SW-1:0]   final_state
);
  function automatic logic [SW-1:0] nxt(input logic b, input logic [SW-1:0] s);
    return TRANS[(32'(b)*NS + 32'(s))*SW +: SW];
  endfunction

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R4
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R4
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(states) && $stable(final_state))); // R5
  AST_FIRST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> states[SW-1:0] == nxt($past(symbols[0]), $past(init_state))); // R2
  AST_LAST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> final_state == nxt($past(symbols[N-1]), states[(N-2)*SW +: SW])); // R3

  for (genvar k = 1; k < N; k++) begin : g_chain
    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> states[k*SW +: SW] == nxt($past(symbols[k]), states[(k-1)*SW +: SW])); // R2
  end
endmodule

bind fsm_prefix_eval fsm_prefix_eval_chk #(.N(N), .SW(SW), .NS(NS), .TRANS(TRANS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .init_state(init_state),
  .symbols(symbols), .out_valid(out_valid), .states(states), .final_state(final_state)
);

// File: tb/fsm_prefix_eval_tb_top.sv
module fsm_prefix_eval_tb_top;
  localparam int N = 16;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [1:0] init_state = '0;
  logic [N-1:0] symbols = '0;
  logic out_valid;
  logic [2*N-1:0] states;
  logic [1:0] final_state;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fsm_prefix_eval dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .init_state(init_state),
    .symbols(symbols), .out_valid(out_valid), .states(states), .final_state(final_state));

  // R1 table, written from the requirement text
  function automatic logic [1:0] step(input logic b, input logic [1:0] s);
    if (!b) case (s) 2'd0: return 2'd1; 2'd1: return 2'd0; 2'd2: return 2'd3; default: return 2'd2; endcase
    else    case (s) 2'd0: return 2'd2; 2'd1: return 2'd3; 2'd2: return 2'd1; default: return 2'd0; endcase
  endfunction

  function automatic logic [2*N-1:0] model(input logic [1:0] s0, input logic [N-1:0] b);
    logic [2*N-1:0] r;
    logic [1:0] s = s0;
    for (int k = 0; k < N; k++) begin
      s = step(b[k], s);
      r[2*k +: 2] = s;
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] s0, input logic [N-1:0] b, input string req);
    logic [2*N-1:0] e;
    e = model(s0, b);
    @(negedge clk);
    init_state = s0; symbols = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R4 out_valid"}, 64'(out_valid), 64'd1);
    chk({req, " R2 states"}, 64'(states), 64'(e));
    chk({req, " R3 final"}, 64'(final_state), 64'(e[2*N-2 +: 2]));
  endtask

  initial begin
    logic [2*N-1:0] held;
    void'($urandom(32'd2024));
    #1;
    chk("R6 out_valid", 64'(out_valid), 64'd0);
    chk("R6 states", 64'(states), 64'd0);
    chk("R6 final", 64'(final_state), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R7 reference run: 0 0 1 1 1 0 1 0 1 from A
    run(2'd0, 16'b0000_0001_0101_1100, "R7");
    chk("R7 slots0-8", 64'(states[17:0]),
        64'({2'd2,2'd0,2'd1,2'd2,2'd3,2'd1,2'd2,2'd0,2'd1}));
    for (int s = 0; s < 4; s++) begin
      run(2'(s), 16'h0000, "R8 zeros");
      chk("R8 zeros return", 64'(final_state), 64'(s));
      run(2'(s), 16'hFFFF, "R8 ones");
      chk("R8 ones return", 64'(final_state), 64'(s));
      run(2'(s), 16'hA5C3, "R8 mixed");
    end
    run(2'd3, 16'h8001, "R2 edges");
    // R5 hold while in_valid low
    held = states;
    @(negedge clk);
    symbols = ~symbols; init_state = 2'd1;
    chk("R4 out_valid low", 64'(out_valid), 64'd0);
    @(negedge clk);
    chk("R5 states held", 64'(states), 64'(held));
    chk("R5 final held", 64'(final_state), 64'(held[2*N-2 +: 2]));
    for (int t = 0; t < 40; t++)
      run(2'($urandom % 4), 16'($urandom), "R2 random");
    // back-to-back blocks
    @(negedge clk);
    init_state = 2'd2; symbols = 16'h1234; in_valid = 1'b1;
    @(negedge clk);
    chk("R2 b2b first", 64'(states), 64'(model(2'd2, 16'h1234)));
    init_state = 2'd1; symbols = 16'hFEDC;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R4 b2b valid", 64'(out_valid), 64'd1);
    chk("R2 b2b second", 64'(states), 64'(model(2'd1, 16'hFEDC)));
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R6 reset again", 64'({out_valid, final_state, states}), 64'd0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R4 watchdog actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule